// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit sits between the byte engine of an I2C controller and the host. It latches one-cycle event pulses from the engine: arbitration lost, no-acknowledge, access ready, receive data ready, transmit ready, stop detected and addressed-as-target. It shows them in a status word, gates them through a mask word, and drives one registered interrupt line. The status word also mirrors two live levels from the engine: receive shift register full and bus busy.

A single vector register returns a small numeric code for the highest-priority event that is both pending and enabled. Reading the vector acknowledges that event, so an interrupt handler can read it in a loop until it returns zero. The receive-ready and transmit-ready flags are the exception. A vector read does not clear them; they clear when the host reads or writes the data register, and those accesses reach this unit as one-cycle strobes. The status word also offers write-one-to-clear on three positions.

Top module: `i2c_irq_vector_unit`

## Requirements
- R1: After reset the status flags, the mask word and the interrupt line are all zero, and the vector reads 0.
- R2: A pulse on event input bit i sets status bit i whether or not it is masked. The event bits are: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed-as-target.
- R3: Status bit 11 follows the receive-shift-full input and status bit 12 follows the bus-busy input, with no latching.
- R4: Writing the status word (select 0) with a 1 in bit 2, 3 or 5 clears that flag. Ones in any other bit position, and all zero bits, leave the flags unchanged.
- R5: The mask word (select 1) stores bits 6..0 of a write and reads back with bits 15..7 as zero.
- R6: The vector (select 2) returns event index + 1 for the lowest-indexed event that is both pending and enabled, giving codes 1 to 7. It returns 0 when no such event exists.
- R7: A vector read clears the flag whose code it returns, except for code 4 (receive ready) and code 5 (transmit ready). Those two stay set.
- R8: A data-read strobe clears the receive-ready flag, and a data-write strobe clears the transmit-ready flag.
- R9: An event pulse in the same cycle as any clear of its flag wins, so the flag stays set.
- R10: The interrupt line is registered. One cycle after any enabled flag is pending it is 1, and otherwise it is 0. Masked flags never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 7 | Event pulses from the byte engine, indexed as in R2 |
| rs_full | input | 1 | Receive shift register full level |
| bus_busy | input | 1 | Bus busy level |
| dat_rd | input | 1 | Host read of the receive data register |
| dat_wr | input | 1 | Host write of the transmit data register |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the select |
| irq | output | 1 | Registered interrupt request |

## Verification
The set and clear paths of a flag can meet in one cycle. An engine pulse can arrive together with a write-one-clear of the status word, or together with the vector read that acknowledges the same event. The bench provokes both collisions by driving the event pulse and the host access in the same low clock phase. It judges them through the host port: the status word must still show the flag, and the vector must still return the same code. A further pair of reads then confirms that a clear with no competing pulse removes the flag.

// File: rtl/i2c_ivu_pkg.sv
package i2c_ivu_pkg;
   localparam int EVT_N      = 7;
   localparam int IDX_AL     = 0;
   localparam int IDX_RX     = 3;
   localparam int IDX_TX     = 4;
   localparam int POS_RSFULL = 11;
   localparam int POS_BUSY   = 12;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_VECTOR = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/ivu_flag_bank.sv
module ivu_flag_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flags
);
   // one sticky cell per event; a set beats a clear in the same cycle
   for (genvar i = 0; i < N; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n) flags[i] <= 1'b0;
         else        flags[i] <= set[i] | (flags[i] & ~clr[i]);
      end

      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags[i]);
      assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flags[i]);
   end
endmodule

// File: rtl/ivu_prio_pick.sv
module ivu_prio_pick #(
   parameter int N      = 7,
   parameter int CODE_W = $clog2(N + 1)
) (
   input  logic [N-1:0]      req,
   output logic [CODE_W-1:0] code,
   output logic [N-1:0]      grant
);
   // scan downwards so the lowest index is written last and wins
   always_comb begin
      code  = '0;
      grant = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            code  = CODE_W'(i + 1);
            grant = N'(1) << i;
         end
      end
   end
endmodule

// File: rtl/i2c_irq_vector_unit.sv
module i2c_irq_vector_unit
   import i2c_ivu_pkg::*;
#(
   parameter int          REG_W    = 16,
   parameter int          NEVT     = EVT_N,
   parameter logic [15:0] W1C_BITS = 16'h002C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEVT-1:0] evt_pulse,
   input  logic            rs_full,
   input  logic            bus_busy,
   input  logic            dat_rd,
   input  logic            dat_wr,
   input  logic [1:0]      reg_sel,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic            irq
);
   localparam int CODE_W = $clog2(NEVT + 1);
   localparam logic [NEVT-1:0] KEEP_ON_VEC = (NEVT'(1) << IDX_RX) | (NEVT'(1) << IDX_TX);

   if (REG_W <= POS_BUSY) begin : g_bad_width
      $error("REG_W too narrow for status level bits");
   end
   if (NEVT != EVT_N) begin : g_bad_evt
      $error("event count must match the code table");
   end
   if (CODE_W > REG_W) begin : g_bad_code
      $error("vector code does not fit the register");
   end

   logic [NEVT-1:0]   flags, clr, pend, grant, mask_q;
   logic [CODE_W-1:0] vec_code;
   logic              vec_rd, st_wr, mask_wr, irq_q;
   logic [REG_W-1:0]  st_word;

   assign vec_rd  = reg_rd && (reg_sel == SEL_VECTOR);
   assign st_wr   = reg_wr && (reg_sel == SEL_STATUS);
   assign mask_wr = reg_wr && (reg_sel == SEL_MASK);

   always_comb begin
      clr = '0;
      if (st_wr)  clr |= reg_wdata[NEVT-1:0] & W1C_BITS[NEVT-1:0];
      if (vec_rd) clr |= grant & ~KEEP_ON_VEC;
      clr[IDX_RX] = clr[IDX_RX] | dat_rd;
      clr[IDX_TX] = clr[IDX_TX] | dat_wr;
   end

   ivu_flag_bank #(.N(NEVT)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_pulse),
      .clr   (clr),
      .flags (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= reg_wdata[NEVT-1:0];
   end

   assign pend = flags & mask_q;

   ivu_prio_pick #(.N(NEVT), .CODE_W(CODE_W)) u_pick (
      .req   (pend),
      .code  (vec_code),
      .grant (grant)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |pend;
   end
   assign irq = irq_q;

   always_comb begin
      st_word              = '0;
      st_word[NEVT-1:0]    = flags;
      st_word[POS_RSFULL]  = rs_full;
      st_word[POS_BUSY]    = bus_busy;
      case (reg_sel)
         SEL_STATUS: reg_rdata = st_word;
         SEL_MASK:   reg_rdata = REG_W'(mask_q);
         SEL_VECTOR: reg_rdata = REG_W'(vec_code);
         default:    reg_rdata = '0;
      endcase
   end

   assert_vec_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_code == '0) == (pend == '0));
   assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |=> !irq);
   assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q));
   assert_rx_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && grant[IDX_RX] && !dat_rd && !(st_wr && reg_wdata[IDX_RX])) |=> flags[IDX_RX]);
   assert_al_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_rd && grant[IDX_AL] && !evt_pulse[IDX_AL]) |=> !flags[IDX_AL]);
endmodule

// File: tb/tb_i2c_irq_vector_unit.sv
module tb_i2c_irq_vector_unit;
   localparam int PER = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  evt_pulse = '0;
   logic        rs_full = 1'b0, bus_busy = 1'b0, dat_rd = 1'b0, dat_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;

   int checks = 0, fails = 0;
   bit done = 0;

   typedef struct {
      bit          is_irq;
      logic [15:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sbq[$];
   event     smp;

   always #(PER/2) clk = ~clk;

   i2c_irq_vector_unit dut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .rs_full(rs_full),
      .bus_busy(bus_busy), .dat_rd(dat_rd), .dat_wr(dat_wr), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // monitor: pops expected items and compares in the low phase
   initial begin
      forever begin
         @(smp);
         #1;
         while (sbq.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? {15'd0, irq} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               fails++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic idle();
      evt_pulse = '0; reg_wr = 0; reg_rd = 0; dat_rd = 0; dat_wr = 0; reg_sel = 2'd3;
   endtask

   task automatic cyc();
      @(negedge clk);
      idle();
   endtask

   task automatic pulse(input logic [6:0] ev);
      evt_pulse = ev;
      cyc();
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d, input logic [6:0] ev);
      reg_sel = sel; reg_wdata = d; reg_wr = 1; evt_pulse = ev;
      cyc();
   endtask

   task automatic rd(input logic [1:0] sel, input logic [15:0] e, input logic [6:0] ev,
                     input string tag);
      sb_item_t it;
      reg_sel = sel; reg_rd = 1; evt_pulse = ev;
      it.is_irq = 0; it.exp = e; it.tag = tag;
      sbq.push_back(it);
      -> smp;
      cyc();
   endtask

   task automatic irq_chk(input logic e, input string tag);
      sb_item_t it;
      it.is_irq = 1; it.exp = {15'd0, e}; it.tag = tag;
      sbq.push_back(it);
      -> smp;
      cyc();
   endtask

   task automatic dstrobe(input logic r, input logic w);
      dat_rd = r; dat_wr = w;
      cyc();
   endtask

   initial begin
      #(PER * 20000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cyc();
      // R1 reset state
      rd(2'd0, 16'h0000, 0, "R1 status after reset");
      rd(2'd1, 16'h0000, 0, "R1 mask after reset");
      rd(2'd2, 16'h0000, 0, "R1 vector after reset");
      irq_chk(0, "R1 irq after reset");
      // R2 masked event still latches
      pulse(7'h01);
      rd(2'd0, 16'h0001, 0, "R2 arb-lost sets bit0 while masked");
      rd(2'd2, 16'h0000, 0, "R6 masked event hidden from vector");
      irq_chk(0, "R10 masked event keeps irq low");
      // R3 live levels
      rs_full = 1; bus_busy = 1;
      rd(2'd0, 16'h1801, 0, "R3 levels at bits 11 and 12");
      rs_full = 0; bus_busy = 0;
      rd(2'd0, 16'h0001, 0, "R3 levels follow without latching");
      // R5 mask word
      wr(2'd1, 16'hFFFF, 0);
      rd(2'd1, 16'h007F, 0, "R5 mask upper bits read zero");
      wr(2'd1, 16'h0055, 0);
      rd(2'd1, 16'h0055, 0, "R5 mask readback");
      wr(2'd1, 16'h007F, 0);
      cyc();
      irq_chk(1, "R10 irq after enabling pending flag");
      // R6/R7/R8 full vector walk
      pulse(7'h7F);
      rd(2'd0, 16'h007F, 0, "R2 all events set bits 6..0");
      rd(2'd2, 16'd1, 0, "R6 code 1 first");
      rd(2'd2, 16'd2, 0, "R7 code 1 acked, next 2");
      rd(2'd2, 16'd3, 0, "R7 next 3");
      rd(2'd2, 16'd4, 0, "R6 next 4");
      rd(2'd2, 16'd4, 0, "R7 receive ready not cleared by vector");
      dstrobe(1, 0);
      rd(2'd2, 16'd5, 0, "R8 data read clears receive ready");
      rd(2'd2, 16'd5, 0, "R7 transmit ready not cleared by vector");
      dstrobe(0, 1);
      rd(2'd2, 16'd6, 0, "R8 data write clears transmit ready");
      rd(2'd2, 16'd7, 0, "R7 next 7");
      rd(2'd2, 16'd0, 0, "R6 vector empty");
      cyc();
      irq_chk(0, "R10 irq drops when nothing pending");
      // R4 write-one-clear
      pulse(7'h7F);
      wr(2'd0, 16'h0000, 0);
      rd(2'd0, 16'h007F, 0, "R4 zero write has no effect");
      wr(2'd0, 16'hFFFF, 0);
      rd(2'd0, 16'h0053, 0, "R4 only bits 2,3,5 clear");
      rd(2'd2, 16'd1, 0, "R7 cleanup 1");
      rd(2'd2, 16'd2, 0, "R7 cleanup 2");
      rd(2'd2, 16'd5, 0, "R7 cleanup 5");
      dstrobe(0, 1);
      rd(2'd2, 16'd7, 0, "R7 cleanup 7");
      rd(2'd2, 16'd0, 0, "R6 empty after cleanup");
      // R6 priority among enabled only
      wr(2'd1, 16'h0020, 0);
      pulse(7'h21);
      rd(2'd2, 16'd6, 0, "R6 masked code 1 skipped, code 6 reported");
      rd(2'd2, 16'd0, 0, "R6 nothing enabled left");
      rd(2'd0, 16'h0001, 0, "R7 masked flag untouched by vector read");
      wr(2'd1, 16'h007F, 0);
      rd(2'd2, 16'd1, 0, "R6 unmasked code 1");
      rd(2'd2, 16'd0, 0, "R6 empty again");
      // R9 collisions
      pulse(7'h04);
      wr(2'd0, 16'h0004, 7'h04);
      rd(2'd0, 16'h0004, 0, "R9 set beats write-one-clear");
      rd(2'd2, 16'd3, 7'h04, "R9 vector read with same event");
      rd(2'd2, 16'd3, 0, "R9 flag survived vector read");
      rd(2'd2, 16'd0, 0, "R7 plain read then clears");
      // R10 masked event does not raise irq
      wr(2'd1, 16'h0000, 0);
      pulse(7'h02);
      cyc();
      irq_chk(0, "R10 masked nack keeps irq low");
      rd(2'd0, 16'h0002, 0, "R2 nack sets bit1");
      wr(2'd1, 16'h007F, 0);
      cyc();
      irq_chk(1, "R10 irq one cycle after unmask");
      rd(2'd2, 16'd2, 0, "R6 code 2");
      rd(2'd2, 16'd0, 0, "R7 nack acked");
      cyc();
      cyc();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule